// File: doc/BRIEF.md
# Interleaved Two-Channel Converter Input Demultiplexer

This block is the digital front end of a two-channel converter run in interleaved mode. A single shared data port carries samples for both channels. A write strobe stores each word in one of two channel input latches, and a select line picks which one. A separate update strobe moves both input latches into the output latches at the same time. The update strobe is divided by two inside the block, so the outputs change only on alternate update edges.

An active-high update hold input keeps the divider idle while it is high. The first update edge after the hold is released always loads the outputs. Software uses this to decide which sample pair is presented to the converters. A mode input selects between interleaved operation and dual-port operation. When dual-port is selected, this front end is disabled.

All inputs are level signals that are already synchronous to the system clock. The block finds their rising edges internally. A one-cycle pulse marks every output update.

Top module: `iq_dac_front`

## Requirements
- R1: After system reset, both input latches and both outputs are zero, and `upd_pulse` is low.
- R2: On a rising edge of `wr_strb`, `data_in` is stored in the channel A input latch when `chan_sel` is 1, and in the channel B input latch when `chan_sel` is 0.
- R3: While `upd_hold` is high, update edges have no effect: the outputs keep their values and `upd_pulse` stays low.
- R4: The first rising edge of `upd_clk` after `upd_hold` goes low loads both outputs from their input latches together.
- R5: After that first load, only every second rising edge of `upd_clk` loads the outputs; the edges in between are skipped.
- R6: When a write edge and a loading update edge arrive in the same cycle, the outputs take the input latch contents from before the new capture.
- R7: While `mode_dual` is 1, write and update edges are ignored: the latches and outputs hold, and the divider returns to its idle phase. The next update edge after `mode_dual` returns to 0 therefore loads the outputs.
- R8: `upd_pulse` is high for exactly one cycle, in the same cycle that the new output values appear. The outputs never change while it is low.
- R9: `chan_sel` changes only in cycles where both `wr_strb` and `upd_clk` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_dual | input | 1 | 1 selects dual-port operation and disables this front end; 0 selects interleaved operation |
| wr_strb | input | 1 | Shared write strobe, level signal; a capture happens on its rising edge |
| upd_clk | input | 1 | Update strobe, level signal; the divide-by-two counts its rising edges |
| chan_sel | input | 1 | Channel steering: 1 selects channel A, 0 selects channel B |
| upd_hold | input | 1 | Active-high update hold; it also realigns the divider phase |
| data_in | input | DATA_W | Shared sample word |
| out_a | output | DATA_W | Channel A output latch |
| out_b | output | DATA_W | Channel B output latch |
| upd_pulse | output | 1 | One-cycle marker of an output update |

## Verification
The assertions assume that `chan_sel` is steady whenever either strobe is high. They also assume that a strobe, once raised, returns low before it is counted again. The stimulus changes the select line only in a cycle where it also drives both strobes low. Every strobe is driven as a pulse followed by at least one low cycle. The random phase keeps these rules and varies the spacing of the strobes, the hold input and the mode input. A behavioural model that counts update edges follows the outputs and the update pulse on every cycle.

// File: rtl/iq_dac_pkg.sv
package iq_dac_pkg;

  parameter int unsigned SAMPLE_W = 12;

  // Divider phase: idle while held, then alternate between a loading
  // edge and a skipped edge.
  typedef enum logic [1:0] {
    DIV_IDLE      = 2'd0,
    DIV_FIRE_NEXT = 2'd1,
    DIV_SKIP_NEXT = 2'd2
  } div_state_t;

endpackage

// File: rtl/iq_edge_detect.sv
module iq_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_d;
    always_comb prev_d = lvl_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= prev_d;
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/iq_input_latch.sv
module iq_input_latch #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] lat_a_o,
  output logic [DATA_W-1:0] lat_b_o
);

  logic [DATA_W-1:0] lat_a_d, lat_b_d;
  logic              en_a, en_b;

  always_comb begin
    en_a    = cap_en_i &  sel_i;
    en_b    = cap_en_i & ~sel_i;
    lat_a_d = data_i;
    lat_b_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a_o <= '0;
      lat_b_o <= '0;
    end else begin
      if (en_a) lat_a_o <= lat_a_d;
      if (en_b) lat_b_o <= lat_b_d;
    end
  end

  // R2
  steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_i |=> (($past(sel_i) ? lat_a_o : lat_b_o) == $past(data_i)));

endmodule

// File: rtl/iq_update_div.sv
module iq_update_div
  import iq_dac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic rise_i,
  output logic fire_o
);

  div_state_t st_q, st_d;

  always_comb begin
    st_d   = st_q;
    fire_o = 1'b0;
    if (hold_i) begin
      st_d = DIV_IDLE;
    end else if (rise_i) begin
      if (st_q == DIV_SKIP_NEXT) begin
        st_d = DIV_FIRE_NEXT;
      end else begin
        fire_o = 1'b1;
        st_d   = DIV_SKIP_NEXT;
      end
    end else if (st_q == DIV_IDLE) begin
      st_d = DIV_FIRE_NEXT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DIV_IDLE;
    else        st_q <= st_d;
  end

  // R5
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !$past(hold_i)) |-> $past(st_q) != DIV_SKIP_NEXT);

endmodule

// File: rtl/iq_dac_front.sv
module iq_dac_front
  import iq_dac_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dual,
  input  logic              wr_strb,
  input  logic              upd_clk,
  input  logic              chan_sel,
  input  logic              upd_hold,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic              upd_pulse
);

  localparam int unsigned STROBE_N = 2;
  localparam int unsigned WR_IDX   = 0;
  localparam int unsigned UPD_IDX  = 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [STROBE_N-1:0] lvl, rise;
  logic                cap_en, div_hold, fire;
  logic [DATA_W-1:0]   lat_a, lat_b;
  logic [DATA_W-1:0]   out_a_d, out_b_d;

  assign lvl[WR_IDX]  = wr_strb;
  assign lvl[UPD_IDX] = upd_clk;

  iq_edge_detect #(.N(STROBE_N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  assign cap_en   = rise[WR_IDX] & ~mode_dual;
  assign div_hold = upd_hold | mode_dual;

  iq_input_latch #(.DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en_i (cap_en),
    .sel_i    (chan_sel),
    .data_i   (data_in),
    .lat_a_o  (lat_a),
    .lat_b_o  (lat_b)
  );

  iq_update_div u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hold_i (div_hold),
    .rise_i (rise[UPD_IDX]),
    .fire_o (fire)
  );

  always_comb begin
    out_a_d = out_a;
    out_b_d = out_b;
    if (fire) begin
      out_a_d = lat_a;
      out_b_d = lat_b;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_a     <= '0;
      out_b     <= '0;
      upd_pulse <= 1'b0;
    end else begin
      out_a     <= out_a_d;
      out_b     <= out_b_d;
      upd_pulse <= fire;
    end
  end

  // R9
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(chan_sel) |-> (!wr_strb && !upd_clk));

  // R3
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_hold |=> ($stable(out_a) && $stable(out_b) && !upd_pulse));

  // R7
  dual_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mode_dual |=> ($stable(out_a) && $stable(out_b) && !upd_pulse));

  // R6
  pair_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_pulse |-> (out_a == $past(lat_a) && out_b == $past(lat_b)));

  // R8
  change_marked_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$stable(out_a) || !$stable(out_b)) |-> upd_pulse);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_pulse |=> !upd_pulse);

endmodule

// File: tb/iq_dac_front_tb.sv
module iq_dac_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_dual = 1'b0;
  logic         wr_strb = 1'b0;
  logic         upd_clk = 1'b0;
  logic         chan_sel = 1'b0;
  logic         upd_hold = 1'b1;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] out_a, out_b;
  logic         upd_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_dac_front #(.DATA_W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dual (mode_dual),
    .wr_strb   (wr_strb),
    .upd_clk   (upd_clk),
    .chan_sel  (chan_sel),
    .upd_hold  (upd_hold),
    .data_in   (data_in),
    .out_a     (out_a),
    .out_b     (out_b),
    .upd_pulse (upd_pulse)
  );

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference: counts update edges since the last hold
  int m_la, m_lb, m_oa, m_ob, m_cnt;
  bit m_pulse, m_pw, m_pu;

  always @(posedge clk) begin
    bit wr_r, up_r, fire;
    if (!rst_n) begin
      m_la = 0; m_lb = 0; m_oa = 0; m_ob = 0; m_cnt = 0;
      m_pulse = 0; m_pw = 0; m_pu = 0;
    end else begin
      wr_r = wr_strb && !m_pw;
      up_r = upd_clk && !m_pu;
      fire = !mode_dual && !upd_hold && up_r && (m_cnt % 2 == 0);
      if (mode_dual || upd_hold) m_cnt = 0;
      else if (up_r)             m_cnt++;
      m_pulse = fire;
      if (fire) begin
        m_oa = m_la;
        m_ob = m_lb;
      end
      if (!mode_dual && wr_r) begin
        if (chan_sel) m_la = int'(data_in);
        else          m_lb = int'(data_in);
      end
      m_pw = wr_strb;
      m_pu = upd_clk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 model out_a", int'(out_a), m_oa);
      check("R5 model out_b", int'(out_b), m_ob);
      check("R8 model upd_pulse", int'(upd_pulse), int'(m_pulse));
      if (upd_pulse) pulse_cnt++;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input bit s, input int d);
    chan_sel = s;
    data_in  = d[W-1:0];
    tick();
    wr_strb = 1'b1;
    tick();
    wr_strb = 1'b0;
    tick();
  endtask

  task automatic do_update();
    upd_clk = 1'b1;
    tick();
    upd_clk = 1'b0;
    tick();
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      finish_run();
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(4);
    check("R1 reset out_a", int'(out_a), 0);
    check("R1 reset out_b", int'(out_b), 0);
    check("R1 reset upd_pulse", int'(upd_pulse), 0);

    // R3: updates while held
    do_write(1'b1, 'h123);
    do_write(1'b0, 'h456);
    do_update();
    do_update();
    check("R3 held out_a", int'(out_a), 0);
    check("R3 held out_b", int'(out_b), 0);

    upd_hold = 1'b0;
    tick();
    do_update();
    check("R4 first edge out_a", int'(out_a), 'h123);
    check("R2 sel0 to channel B", int'(out_b), 'h456);

    do_write(1'b1, 'h7AB);
    do_update();
    check("R5 skipped edge out_a", int'(out_a), 'h123);
    do_update();
    check("R5 second edge out_a", int'(out_a), 'h7AB);

    // R6: skip one edge, then write and update in the same cycle
    do_update();
    do_write(1'b0, 'h0F0);
    chan_sel = 1'b1;
    data_in  = 'hABC;
    tick();
    wr_strb = 1'b1;
    upd_clk = 1'b1;
    tick();
    wr_strb = 1'b0;
    upd_clk = 1'b0;
    tick();
    check("R6 same cycle out_a", int'(out_a), 'h7AB);
    check("R6 same cycle out_b", int'(out_b), 'h0F0);

    // R4: hold realigns the phase
    upd_hold = 1'b1;
    tick();
    upd_hold = 1'b0;
    tick();
    do_update();
    check("R4 realigned out_a", int'(out_a), 'hABC);

    // R7: dual-port mode ignores the strobes
    mode_dual = 1'b1;
    tick();
    do_write(1'b1, 'h111);
    do_update();
    do_update();
    check("R7 dual out_a", int'(out_a), 'hABC);
    check("R7 dual upd_pulse", int'(upd_pulse), 0);
    mode_dual = 1'b0;
    tick();
    do_update();
    check("R7 latch kept after dual", int'(out_a), 'hABC);
    check("R8 pulse count", pulse_cnt, 5);

    // random phase keeping the R9 input rule
    for (int i = 0; i < 3000; i++) begin
      bit nw, nu;
      nw = ($urandom % 3 == 0) && !wr_strb;
      nu = ($urandom % 3 == 0) && !upd_clk;
      wr_strb  = nw;
      upd_clk  = nu;
      data_in  = W'($urandom);
      if (!nw && !nu && ($urandom % 2 == 0)) chan_sel = ~chan_sel;
      if ($urandom % 40 == 0) upd_hold = ~upd_hold;
      if ($urandom % 97 == 0) mode_dual = ~mode_dual;
      tick();
    end
    wr_strb = 1'b0;
    upd_clk = 1'b0;
    tick(3);
    finish_run();
  end

endmodule